// File: doc/BRIEF.md
# Fast-Charge Safety Timer

This block bounds how long a battery charger may stay in its fast-charge phase. While the timer is enabled and charging is active, it counts pulses of an external time base. Once the elapsed count reaches the duration picked by a 2-bit code, it raises a fault flag. Charger control logic uses that flag to end the charge.

The count restarts whenever the duration code takes a new value. It also clears whenever the timer is disabled or charging stops. When slowdown is enabled and the charger reports that it is being throttled (input power limiting or thermal regulation), only every second time-base pulse advances the count. This stretches the allowed time to make up for the reduced charge current.

The parameter `TICKS_PER_HOUR` sets how many time-base pulses make one hour. A small value gives short runs in simulation.

Top module: `chg_safety_timer`

## Requirements
- R1: After reset, `fault` is 0.
- R2: The duration code selects a limit of H x `TICKS_PER_HOUR` counted advances. H is 5 for code 0, 8 for code 1, 12 for code 2 and 20 for code 3. `fault` rises on the advance that reaches the limit and not one advance earlier.
- R3: When `dur_code` differs from its value in the previous cycle, the count returns to zero and `fault` clears. The full limit of the new code must then elapse.
- R4: While `slow_en` and `throttle` are both 1, only every second `tick` advances the count. The first throttled tick after a clear or after an advance does not count.
- R5: While `slow_en` is 0, every `tick` advances the count whatever the value of `throttle`.
- R6: While `tmr_en` is 0 or `chg_active` is 0, the count is held at zero and `fault` is 0. Counting starts again from zero when both return to 1.
- R7: Once set, `fault` stays 1 while the timer runs and the code is unchanged. This holds however many further ticks arrive and whatever the state of `throttle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Safety timer enable |
| dur_code | input | 2 | Duration select (0: 5 h, 1: 8 h, 2: 12 h, 3: 20 h) |
| slow_en | input | 1 | Allow half-rate counting while throttled |
| chg_active | input | 1 | Fast charge in progress |
| throttle | input | 1 | Input power limiting or thermal regulation active |
| tick | input | 1 | One-cycle time-base pulse |
| fault | output | 1 | Duration elapsed |

## Verification
Every duration code is run to one tick short of its limit and then to the limit exactly. A design with a wrong hour mapping, or with an off-by-one in the compare, would set `fault` one tick early or one tick late.

Throttled runs, both full and mixed with unthrottled ticks, check the half-rate phase. A toggle that starts on the wrong phase, or that is not cleared, shifts the fault by one tick. A gate that ignores `slow_en` stretches the run in which `slow_en` is 0.

A code change made midway through a run must force a full restart, and a change made after the fault must clear the flag. The bench drops the enable and charging inputs after a fault and while ticks keep arriving. This shows that the flag falls, that the count does not resume from a stale value, and that the flag stays latched while the timer runs.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int unsigned MAX_HOURS = 20;
  localparam logic [1:0]  CODE_AT_RESET = 2'd2;

  function automatic int unsigned hours_of(input logic [1:0] code);
    case (code)
      2'd0:    hours_of = 5;
      2'd1:    hours_of = 8;
      2'd2:    hours_of = 12;
      default: hours_of = 20;
    endcase
  endfunction
endpackage

// File: rtl/sft_code_watch.sv
module sft_code_watch
  import sft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dur_code,
  output logic       restart
);
  logic [1:0] code_q;
  logic [1:0] code_d;

  always_comb begin
    code_d  = dur_code;
    restart = (dur_code != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= CODE_AT_RESET;
    else        code_q <= code_d;
  end

  // R3: a restart is a single-cycle event unless the code moves again
  p_restart_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!restart || dur_code != $past(dur_code)));
endmodule

// File: rtl/sft_rate_gate.sv
module sft_rate_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic half,
  input  logic clr,
  output logic adv
);
  logic phase_q;
  logic phase_d;
  logic phase_en;

  always_comb begin
    phase_en = clr || !half || tick;
    if (clr || !half) phase_d = 1'b0;
    else              phase_d = ~phase_q;
    adv = tick && !clr && (!half || phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (phase_en) phase_q <= phase_d;
  end

  // R4: two throttled advances are never adjacent
  p_half_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half && !clr && adv) |=> (!half || clr || !adv));
  // R5: at full rate every tick passes
  p_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !half && !clr) |-> adv);
endmodule

// File: rtl/sft_fault_counter.sv
module sft_fault_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             fault
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             fault_q;
  logic             fault_d;
  logic             upd_en;

  always_comb begin
    upd_en  = clr || (adv && !fault_q);
    cnt_d   = cnt_q;
    fault_d = fault_q;
    if (clr) begin
      cnt_d   = '0;
      fault_d = 1'b0;
    end else if (adv && !fault_q) begin
      cnt_d   = cnt_q + 1'b1;
      fault_d = (cnt_q + 1'b1) >= limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;

  // R3: a clear leaves nothing behind
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !fault_q));
  // R7: a set fault holds until a clear
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr) |=> fault_q);
  // R2: the count moves by at most one per cycle
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
  import sft_pkg::*;
#(
  parameter int unsigned TICKS_PER_HOUR = 3600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmr_en,
  input  logic [1:0] dur_code,
  input  logic       slow_en,
  input  logic       chg_active,
  input  logic       throttle,
  input  logic       tick,
  output logic       fault
);
  localparam int unsigned MAX_TICKS = MAX_HOURS * TICKS_PER_HOUR;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             run;
  logic             restart;
  logic             clr;
  logic             half;
  logic             adv;
  logic [CNT_W-1:0] limit;

  always_comb begin
    run   = tmr_en && chg_active;
    clr   = !run || restart;
    half  = slow_en && throttle;
    limit = CNT_W'(hours_of(dur_code) * TICKS_PER_HOUR);
  end

  sft_code_watch u_code_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .dur_code (dur_code),
    .restart  (restart)
  );

  sft_rate_gate u_rate_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .half  (half),
    .clr   (clr),
    .adv   (adv)
  );

  sft_fault_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .adv   (adv),
    .limit (limit),
    .fault (fault)
  );

  // R6: an idle timer reports no fault
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_en && chg_active) |=> !fault);
  // R3: a code change drops the flag
  p_code_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dur_code != $past(dur_code)) |=> !fault);
endmodule

// File: tb/test_chg_safety_timer.sv
module test_chg_safety_timer;
  localparam int unsigned TPH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_en = 1'b1;
  logic [1:0] dur_code = 2'd2;
  logic       slow_en = 1'b1;
  logic       chg_active = 1'b1;
  logic       throttle = 1'b0;
  logic       tick = 1'b0;
  logic       fault;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  chg_safety_timer #(.TICKS_PER_HOUR(TPH)) i_chg_safety_timer (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .dur_code(dur_code),
    .slow_en(slow_en), .chg_active(chg_active), .throttle(throttle),
    .tick(tick), .fault(fault)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int limit_of(input logic [1:0] c);
    case (c)
      2'd0: return 5 * TPH;
      2'd1: return 8 * TPH;
      2'd2: return 12 * TPH;
      default: return 20 * TPH;
    endcase
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (fault !== exp) begin
      failures++;
      $display("FAIL %s: fault actual=%b expected=%b", req, fault, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic fresh(input logic [1:0] c, input logic s, input logic t);
    @(negedge clk) chg_active = 1'b0;
    idle(2);
    dur_code = c; slow_en = s; throttle = t; tmr_en = 1'b1;
    idle(2);
    chg_active = 1'b1;
    idle(2);
  endtask

  task automatic t_reset;
    idle(1);
    check("R1", 1'b0);
  endtask

  task automatic t_durations;
    for (int c = 0; c < 4; c++) begin
      fresh(2'(c), 1'b1, 1'b0);
      ticks(limit_of(2'(c)) - 1);
      check("R2", 1'b0);
      ticks(1);
      check("R2", 1'b1);
    end
  endtask

  task automatic t_half_rate;
    fresh(2'd0, 1'b1, 1'b1);
    ticks(2 * limit_of(2'd0) - 1);
    check("R4", 1'b0);
    ticks(1);
    check("R4", 1'b1);
    // mixed: 4 throttled ticks give 2 advances
    fresh(2'd0, 1'b1, 1'b1);
    ticks(4);
    throttle = 1'b0;
    ticks(limit_of(2'd0) - 3);
    check("R4", 1'b0);
    ticks(1);
    check("R4", 1'b1);
  endtask

  task automatic t_slow_off;
    fresh(2'd0, 1'b0, 1'b1);
    ticks(limit_of(2'd0) - 1);
    check("R5", 1'b0);
    ticks(1);
    check("R5", 1'b1);
  endtask

  task automatic t_restart;
    fresh(2'd1, 1'b1, 1'b0);
    ticks(limit_of(2'd1) - 4);
    dur_code = 2'd0;
    idle(1);
    ticks(limit_of(2'd0) - 1);
    check("R3", 1'b0);
    ticks(1);
    check("R3", 1'b1);
    dur_code = 2'd3;
    idle(1);
    check("R3", 1'b0);
  endtask

  task automatic t_idle;
    fresh(2'd0, 1'b1, 1'b0);
    ticks(limit_of(2'd0));
    check("R6", 1'b1);
    tmr_en = 1'b0;
    idle(1);
    check("R6", 1'b0);
    ticks(limit_of(2'd0) + 3);
    check("R6", 1'b0);
    tmr_en = 1'b1;
    idle(1);
    ticks(limit_of(2'd0) - 1);
    check("R6", 1'b0);
    chg_active = 1'b0;
    idle(1);
    chg_active = 1'b1;
    idle(1);
    ticks(limit_of(2'd0) - 1);
    check("R6", 1'b0);
    ticks(1);
    check("R6", 1'b1);
  endtask

  task automatic t_sticky;
    fresh(2'd0, 1'b1, 1'b0);
    ticks(limit_of(2'd0));
    ticks(7);
    check("R7", 1'b1);
    throttle = 1'b1;
    ticks(5);
    throttle = 1'b0;
    idle(3);
    check("R7", 1'b1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_durations();
    t_half_rate();
    t_slow_off();
    t_restart();
    t_idle();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule